// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block supplies the two low address bits for a four-beat burst on a synchronous burst memory. The strobe logic outside it gives a one-cycle load pulse and a two-bit start value. The block holds that start value as beat 0. After that, each clock edge that sees the active-low advance input asserted moves it one beat further through the burst. The burst wraps back to the start value after the fourth beat.

A static strap input picks the burst order. Held low, it selects a linear order that counts upward modulo four from the start. Held high, it selects an interleaved order that XORs the start value with the beat number. The block drives the current burst offset and a flag that marks the last beat of the four. The upper address register, the memory array and the strobe arbitration are not part of this block.

The asynchronous active-low reset takes effect at once. Its release passes through a synchronizer before the sequencer leaves reset.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and until the first operation after reset, `offset_o` is 0 and `last_o` is 0.
- R2: A high `load_i` at a rising clock edge puts `load_val_i` on `offset_o` after that edge as beat 0, with `last_o` low.
- R3: When `load_i` and an asserted `adv_n_i` (low) occur in the same cycle, the load wins and the advance has no effect.
- R4: With `load_i` low and `adv_n_i` high, the edge leaves `offset_o` and `last_o` unchanged.
- R5: With `mode_i` low (linear order), each advancing edge sets `offset_o` to (previous offset + 1) modulo 4. Start 2 gives 2,3,0,1.
- R6: With `mode_i` high (interleaved order), the offset on beat k (k = 0..3) is the start value XOR k. Start 1 gives 1,0,3,2.
- R7: `last_o` is high exactly while the beat number is 3, which is the fourth offset of the burst.
- R8: An advance from the fourth beat returns `offset_o` to the start value with the beat number at 0, and the burst then repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Load pulse from the strobe logic, active high |
| load_val_i | input | 2 | Start offset taken on load |
| adv_n_i | input | 1 | Advance request, active low |
| mode_i | input | 1 | Static order strap: 0 linear, 1 interleaved |
| offset_o | output | 2 | Current burst offset |
| last_o | output | 1 | High on the fourth beat |

## Verification
The bench keeps its own model of the start value and the beat number. It checks the offset and the last-beat flag in every cycle after each edge. A wrong start register or beat counter therefore shows as a wrong offset in the very next cycle after the edge that corrupted it. A beat count that is off by one also moves the last-beat flag to the wrong cycle within the same burst, or breaks the wrap to the start value on the following advance. Both orders are run from several start values, and holds and load-versus-advance collisions are mixed in.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } order_e;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         adv_i,
  output logic [W-1:0] beat_o,
  output logic         last_o
);
  logic [W-1:0] beat_q, beat_d;
  logic         beat_en;

  always_comb begin
    beat_en = load_i | adv_i;
    beat_d  = beat_q;
    if (load_i)     beat_d = '0;
    else if (adv_i) beat_d = beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  assign beat_o = beat_q;
  assign last_o = &beat_q;

  p_load_beat0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (beat_o == '0) && !last_o);
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && adv_i && !load_i) |=> (beat_o == '0));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] beat_i,
  input  order_e       order_i,
  output logic [W-1:0] offset_o
);
  logic [W-1:0] lin_off, ilv_off;

  assign lin_off = start_i + beat_i;

  for (genvar b = 0; b < W; b++) begin : g_xor
    assign ilv_off[b] = start_i[b] ^ beat_i[b];
  end

  always_comb begin
    unique case (order_i)
      ORDER_LINEAR:      offset_o = lin_off;
      ORDER_INTERLEAVED: offset_o = ilv_off;
      default:           offset_o = lin_off;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [1:0] load_val_i,
  input  logic       adv_n_i,
  input  logic       mode_i,
  output logic [1:0] offset_o,
  output logic       last_o
);
  localparam int W = 2;
  localparam int SYNC_STAGES = 2;

  logic         rst_sync_n;
  logic [W-1:0] start_q, start_d;
  logic         start_en;
  logic [W-1:0] beat;
  logic         adv;
  order_e       order;

  burst_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign adv   = ~adv_n_i;
  assign order = order_e'(mode_i);

  always_comb begin
    start_en = load_i;
    start_d  = load_val_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   start_q <= '0;
    else if (start_en) start_q <= start_d;
  end

  burst_beat_ctr #(.W(W)) u_beat (
    .clk(clk), .rst_n(rst_sync_n), .load_i(load_i), .adv_i(adv),
    .beat_o(beat), .last_o(last_o)
  );

  burst_order_map #(.W(W)) u_map (
    .start_i(start_q), .beat_i(beat), .order_i(order), .offset_o(offset_o)
  );

  p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_i |=> (offset_o == $past(load_val_i)));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_i && adv_n_i) |=> ($stable(offset_o) && $stable(last_o)));
  p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_i && !adv_n_i && !mode_i) |=> (offset_o == W'($past(offset_o) + 1'b1)));
  p_ilv_step_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_i && !adv_n_i && mode_i) |=> (offset_o != $past(offset_o)));
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_i = 1'b0;
  logic [1:0] load_val_i = 2'd0;
  logic       adv_n_i = 1'b1;
  logic       mode_i = 1'b0;
  logic [1:0] offset_o;
  logic       last_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0] off;
    logic       last;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic [1:0] m_start = 2'd0;
  logic [1:0] m_beat  = 2'd0;

  always #5 clk = ~clk;

  burst_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_val_i(load_val_i),
    .adv_n_i(adv_n_i), .mode_i(mode_i), .offset_o(offset_o), .last_o(last_o)
  );

  task automatic step(input logic ld, input logic [1:0] val, input logic advn,
                      input logic md, input string tag);
    exp_t e;
    @(negedge clk);
    load_i = ld; load_val_i = val; adv_n_i = advn; mode_i = md;
    @(posedge clk);
    if (ld) begin m_start = val; m_beat = 2'd0; end
    else if (!advn) m_beat = m_beat + 2'd1;
    e.off  = md ? (m_start ^ m_beat) : (m_start + m_beat);
    e.last = (m_beat == 2'd3);
    e.tag  = tag;
    q.push_back(e);
  endtask

  always begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (offset_o !== e.off || last_o !== e.last) begin
        errors++;
        $display("FAIL %s: offset=%0d last=%0b expected offset=%0d last=%0b",
                 e.tag, offset_o, last_o, e.off, e.last);
      end
    end
  end

  task automatic check_reset();
    checks++;
    if (offset_o !== 2'd0 || last_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: offset=%0d last=%0b expected offset=0 last=0", offset_o, last_o);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 check_reset();
    @(negedge clk) rst_n = 1'b1;
    repeat (3) step(1'b0, 2'd0, 1'b1, 1'b0, "R1");
    // linear order from 2
    step(1'b1, 2'd2, 1'b1, 1'b0, "R2");
    step(1'b0, 2'd0, 1'b0, 1'b0, "R5");
    step(1'b0, 2'd0, 1'b0, 1'b0, "R5");
    step(1'b0, 2'd0, 1'b0, 1'b0, "R7");
    step(1'b0, 2'd0, 1'b1, 1'b0, "R4");
    step(1'b0, 2'd0, 1'b1, 1'b0, "R4");
    step(1'b0, 2'd0, 1'b0, 1'b0, "R8");
    step(1'b0, 2'd0, 1'b0, 1'b0, "R5");
    // load together with advance
    step(1'b1, 2'd1, 1'b0, 1'b0, "R3");
    for (int i = 0; i < 5; i++) step(1'b0, 2'd0, 1'b0, 1'b0, "R5");
    step(1'b1, 2'd3, 1'b1, 1'b0, "R2");
    for (int i = 0; i < 4; i++) step(1'b0, 2'd0, 1'b0, 1'b0, "R8");
    // interleaved order
    step(1'b1, 2'd1, 1'b1, 1'b1, "R2");
    for (int i = 0; i < 3; i++) step(1'b0, 2'd0, 1'b0, 1'b1, "R6");
    step(1'b0, 2'd0, 1'b1, 1'b1, "R4");
    step(1'b0, 2'd0, 1'b0, 1'b1, "R8");
    step(1'b1, 2'd2, 1'b0, 1'b1, "R3");
    for (int i = 0; i < 4; i++) step(1'b0, 2'd0, 1'b0, 1'b1, "R6");
    step(1'b1, 2'd3, 1'b1, 1'b1, "R2");
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 2'd0, 1'b0, 1'b1, "R7");
      step(1'b0, 2'd0, 1'b1, 1'b1, "R4");
    end
    step(1'b0, 2'd0, 1'b0, 1'b1, "R8");
    step(1'b1, 2'd0, 1'b1, 1'b1, "R2");
    for (int i = 0; i < 4; i++) step(1'b0, 2'd0, 1'b0, 1'b1, "R6");
    step(1'b0, 2'd0, 1'b1, 1'b1, "R4");
    @(posedge clk); #4;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule